// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds the two 16-bit data pointers of an 8051-style core, together with the two special-function registers that configure them. Each pointer access from the core is either a normal reference or an alternate reference. A swap bit decides which physical pointer answers each kind. The block drives the pointer that the current reference resolves to on its output. It does this combinationally, in the same cycle.

The core signals three events with strobes: a pointer-increment instruction, an indirect external-data or code-table access, and whether the reference is the alternate one. On an increment instruction, the resolved pointer moves by one. Each pointer has its own direction bit, so "increment" can count down. On an indirect access, the resolved pointer is post-modified only when its own update-enable bit is set. Software loads each pointer one byte at a time through dedicated write strobes. It reads and writes the configuration through a byte-wide register port.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset both pointers are 0000h, and the configuration and swap registers read back as 00h.
- R2: `sel_ptr_o` shows pointer 0 when `cmd_alt_i` XOR swap is 0, and pointer 1 otherwise, in the same cycle.
- R3: An increment command changes the resolved pointer by +1 when that pointer's direction bit is 0, and by -1 when it is 1, visible from the next cycle.
- R4: An indirect access on a pointer whose update-enable bit is 1 post-modifies that pointer by one in its direction. During the access cycle `sel_ptr_o` still shows the old value.
- R5: An indirect access on a pointer whose update-enable bit is 0 leaves both pointers unchanged.
- R6: The register at A1h holds, in bit order, update-enable 1 (bit 7), update-enable 0 (bit 6), direction 1 (bit 5) and direction 0 (bit 4). Bits 3..0 read as 0 and ignore writes.
- R7: The register at A2h holds the swap bit in bit 0. Bits 7..1 read as 0 and ignore writes.
- R8: `ptr_wr_lo_i[n]` loads `ptr_wdata_i` into the low byte of physical pointer n. `ptr_wr_hi_i[n]` loads it into the high byte.
- R9: A byte write to a pointer in the same cycle as a step of that pointer wins: the written byte is stored, the other byte keeps its value and the step is dropped.
- R10: A command changes only the resolved pointer. A byte write to the other pointer in the same cycle still takes effect.
- R11: Steps wrap modulo 2^16: FFFFh+1 gives 0000h and 0000h-1 gives FFFFh.
- R12: Register reads at any address other than A1h and A2h return 00h. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address for read and write |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data for `sfr_addr_i` (combinational) |
| ptr_wr_lo_i | input | 2 | Low-byte load strobe, one per physical pointer |
| ptr_wr_hi_i | input | 2 | High-byte load strobe, one per physical pointer |
| ptr_wdata_i | input | 8 | Byte loaded by the pointer strobes |
| cmd_inc_i | input | 1 | Pointer-increment instruction |
| cmd_xacc_i | input | 1 | Indirect external-data or code-table access |
| cmd_alt_i | input | 1 | Current reference is the alternate pointer |
| sel_ptr_o | output | 16 | Pointer resolved by the current reference |
| ptr0_o | output | 16 | Physical pointer 0 |
| ptr1_o | output | 16 | Physical pointer 1 |

## Verification
The assertions check the following on every clock:
- the reference routing against the swap bit;
- the one-step change of pointer 0 under an increment command, in the direction set by its configuration;
- that a disabled indirect access leaves pointer 0 alone;
- that pointer 1 holds when it is neither written nor resolved;
- that a low-byte load always lands;
- that the reserved nibble at A1h reads zero.

Only the bench scenarios show:
- the wrap at both ends of the range;
- that the old value is visible during an access cycle;
- that a load beats a simultaneous step on the same pointer;
- the read-back masking at A2h and at unmapped addresses;
- the effect of a mid-run reset.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    localparam int unsigned NUM_PTR = 2;

    // bit positions inside the configuration register
    localparam int unsigned CFG_UPD1_BIT = 7;
    localparam int unsigned CFG_UPD0_BIT = 6;
    localparam int unsigned CFG_DIR1_BIT = 5;
    localparam int unsigned CFG_DIR0_BIT = 4;

    // bit position of the swap flag inside the auxiliary register
    localparam int unsigned AUX_SWAP_BIT = 0;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_UP   = 2'd1,
        OP_DOWN = 2'd2,
        OP_LOAD = 2'd3
    } ptr_op_e;

endpackage

// File: rtl/dptr_ctrl_regs.sv
module dptr_ctrl_regs #(
    parameter int unsigned  DATA_W   = 8,
    parameter logic [7:0]   ADDR_CFG = 8'hA1,
    parameter logic [7:0]   ADDR_AUX = 8'hA2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sfr_wr_i,
    input  logic [7:0]        sfr_addr_i,
    input  logic [DATA_W-1:0] sfr_wdata_i,
    output logic [1:0]        upd_en_o,
    output logic [1:0]        dir_dn_o,
    output logic              swap_o,
    output logic [DATA_W-1:0] sfr_rdata_o
);
    import dptr_pkg::*;

    logic [1:0] upd_q;
    logic [1:0] dir_q;
    logic       swap_q;
    logic       cfg_hit;
    logic       aux_hit;
    logic       unused_wbits;

    assign cfg_hit      = (sfr_addr_i == ADDR_CFG);
    assign aux_hit      = (sfr_addr_i == ADDR_AUX);
    assign unused_wbits = ^{sfr_wdata_i[CFG_DIR0_BIT-1:AUX_SWAP_BIT+1],
                            sfr_wdata_i[DATA_W-1:CFG_UPD1_BIT]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            upd_q  <= '0;
            dir_q  <= '0;
            swap_q <= 1'b0;
        end else begin
            if (sfr_wr_i && cfg_hit) begin
                upd_q <= {sfr_wdata_i[CFG_UPD1_BIT], sfr_wdata_i[CFG_UPD0_BIT]};
                dir_q <= {sfr_wdata_i[CFG_DIR1_BIT], sfr_wdata_i[CFG_DIR0_BIT]};
            end
            if (sfr_wr_i && aux_hit) begin
                swap_q <= sfr_wdata_i[AUX_SWAP_BIT];
            end
        end
    end

    always_comb begin
        sfr_rdata_o = '0;
        if (cfg_hit) begin
            sfr_rdata_o[CFG_UPD1_BIT] = upd_q[1];
            sfr_rdata_o[CFG_UPD0_BIT] = upd_q[0];
            sfr_rdata_o[CFG_DIR1_BIT] = dir_q[1];
            sfr_rdata_o[CFG_DIR0_BIT] = dir_q[0];
        end else if (aux_hit) begin
            sfr_rdata_o[AUX_SWAP_BIT] = swap_q;
        end
    end

    assign upd_en_o = upd_q;
    assign dir_dn_o = dir_q;
    assign swap_o   = swap_q;

endmodule

// File: rtl/dptr_op_decode.sv
module dptr_op_decode (
    input  logic               cmd_inc_i,
    input  logic               cmd_xacc_i,
    input  logic               cmd_alt_i,
    input  logic               swap_i,
    input  logic [1:0]         upd_en_i,
    input  logic [1:0]         dir_dn_i,
    input  logic [1:0]         wr_lo_i,
    input  logic [1:0]         wr_hi_i,
    output dptr_pkg::ptr_op_e  op_o [dptr_pkg::NUM_PTR]
);
    import dptr_pkg::*;

    logic tgt;
    assign tgt = cmd_alt_i ^ swap_i;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_op
        logic    hit;
        logic    step;
        ptr_op_e op_g;

        assign hit  = (tgt == 1'(g));
        assign step = hit && (cmd_inc_i || (cmd_xacc_i && upd_en_i[g]));

        always_comb begin
            if (wr_lo_i[g] || wr_hi_i[g]) begin
                op_g = OP_LOAD;
            end else if (step) begin
                op_g = dir_dn_i[g] ? OP_DOWN : OP_UP;
            end else begin
                op_g = OP_HOLD;
            end
        end

        assign op_o[g] = op_g;
    end

endmodule

// File: rtl/dptr_slot.sv
module dptr_slot #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  dptr_pkg::ptr_op_e   op_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    output logic [2*BYTE_W-1:0] ptr_o
);
    import dptr_pkg::*;

    localparam int unsigned PTR_W = 2 * BYTE_W;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        unique case (op_i)
            OP_HOLD: ptr_d = ptr_q;
            OP_UP:   ptr_d = ptr_q + PTR_W'(1);
            OP_DOWN: ptr_d = ptr_q - PTR_W'(1);
            OP_LOAD: begin
                if (wr_lo_i) ptr_d[BYTE_W-1:0]     = wdata_i;
                if (wr_hi_i) ptr_d[PTR_W-1:BYTE_W] = wdata_i;
            end
            default: ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/dptr_route.sv
module dptr_route #(
    parameter int unsigned PTR_W = 16
) (
    input  logic             cmd_alt_i,
    input  logic             swap_i,
    input  logic [PTR_W-1:0] ptr0_i,
    input  logic [PTR_W-1:0] ptr1_i,
    output logic [PTR_W-1:0] sel_ptr_o
);
    always_comb begin
        unique case (cmd_alt_i ^ swap_i)
            1'b0:    sel_ptr_o = ptr0_i;
            1'b1:    sel_ptr_o = ptr1_i;
            default: sel_ptr_o = ptr0_i;
        endcase
    end

endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit #(
    parameter int unsigned BYTE_W   = 8,
    parameter logic [7:0]  ADDR_CFG = 8'hA1,
    parameter logic [7:0]  ADDR_AUX = 8'hA2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sfr_wr_i,
    input  logic [7:0]          sfr_addr_i,
    input  logic [BYTE_W-1:0]   sfr_wdata_i,
    output logic [BYTE_W-1:0]   sfr_rdata_o,
    input  logic [1:0]          ptr_wr_lo_i,
    input  logic [1:0]          ptr_wr_hi_i,
    input  logic [BYTE_W-1:0]   ptr_wdata_i,
    input  logic                cmd_inc_i,
    input  logic                cmd_xacc_i,
    input  logic                cmd_alt_i,
    output logic [2*BYTE_W-1:0] sel_ptr_o,
    output logic [2*BYTE_W-1:0] ptr0_o,
    output logic [2*BYTE_W-1:0] ptr1_o
);
    import dptr_pkg::*;

    localparam int unsigned PTR_W = 2 * BYTE_W;

    logic [1:0]       upd_en;
    logic [1:0]       dir_dn;
    logic             swap;
    ptr_op_e          op [NUM_PTR];
    logic [PTR_W-1:0] ptr_q [NUM_PTR];

    dptr_ctrl_regs #(
        .DATA_W   (BYTE_W),
        .ADDR_CFG (ADDR_CFG),
        .ADDR_AUX (ADDR_AUX)
    ) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sfr_wr_i    (sfr_wr_i),
        .sfr_addr_i  (sfr_addr_i),
        .sfr_wdata_i (sfr_wdata_i),
        .upd_en_o    (upd_en),
        .dir_dn_o    (dir_dn),
        .swap_o      (swap),
        .sfr_rdata_o (sfr_rdata_o)
    );

    dptr_op_decode dec_i (
        .cmd_inc_i  (cmd_inc_i),
        .cmd_xacc_i (cmd_xacc_i),
        .cmd_alt_i  (cmd_alt_i),
        .swap_i     (swap),
        .upd_en_i   (upd_en),
        .dir_dn_i   (dir_dn),
        .wr_lo_i    (ptr_wr_lo_i),
        .wr_hi_i    (ptr_wr_hi_i),
        .op_o       (op)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
        dptr_slot #(.BYTE_W(BYTE_W)) slot_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .op_i    (op[g]),
            .wr_lo_i (ptr_wr_lo_i[g]),
            .wr_hi_i (ptr_wr_hi_i[g]),
            .wdata_i (ptr_wdata_i),
            .ptr_o   (ptr_q[g])
        );
    end

    dptr_route #(.PTR_W(PTR_W)) route_i (
        .cmd_alt_i (cmd_alt_i),
        .swap_i    (swap),
        .ptr0_i    (ptr_q[0]),
        .ptr1_i    (ptr_q[1]),
        .sel_ptr_o (sel_ptr_o)
    );

    assign ptr0_o = ptr_q[0];
    assign ptr1_o = ptr_q[1];

endmodule

// File: rtl/dptr_pair_unit_chk.sv
module dptr_pair_unit_chk #(
    parameter int unsigned BYTE_W   = 8,
    parameter logic [7:0]  ADDR_CFG = 8'hA1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [7:0]          sfr_addr_i,
    input logic [BYTE_W-1:0]   sfr_rdata_o,
    input logic [1:0]          ptr_wr_lo_i,
    input logic [1:0]          ptr_wr_hi_i,
    input logic [BYTE_W-1:0]   ptr_wdata_i,
    input logic                cmd_inc_i,
    input logic                cmd_xacc_i,
    input logic                cmd_alt_i,
    input logic [2*BYTE_W-1:0] sel_ptr_o,
    input logic [2*BYTE_W-1:0] ptr0_o,
    input logic [2*BYTE_W-1:0] ptr1_o,
    input logic [1:0]          upd_en,
    input logic [1:0]          dir_dn,
    input logic                swap
);
    localparam int unsigned PTR_W = 2 * BYTE_W;

    logic tgt;
    logic unused_chk;
    assign tgt        = cmd_alt_i ^ swap;
    assign unused_chk = ^{upd_en[1], dir_dn[1]};

    assert_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_ptr_o == (tgt ? ptr1_o : ptr0_o));

    assert_inc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_inc_i && !tgt && ptr_wr_lo_i[0] == 1'b0 && ptr_wr_hi_i[0] == 1'b0)
        |=> ptr0_o == ($past(dir_dn[0]) ? $past(ptr0_o) - PTR_W'(1)
                                        : $past(ptr0_o) + PTR_W'(1)));

    assert_no_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_xacc_i && !cmd_inc_i && !tgt && !upd_en[0]
         && ptr_wr_lo_i[0] == 1'b0 && ptr_wr_hi_i[0] == 1'b0)
        |=> $stable(ptr0_o));

    assert_other_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ptr_wr_lo_i[1] && !ptr_wr_hi_i[1] && (!tgt || (!cmd_inc_i && !cmd_xacc_i)))
        |=> $stable(ptr1_o));

    assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_wr_lo_i[0] |=> ptr0_o[BYTE_W-1:0] == $past(ptr_wdata_i));

    assert_cfg_reserved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sfr_addr_i == ADDR_CFG) |-> sfr_rdata_o[3:0] == 4'h0);

endmodule

bind dptr_pair_unit dptr_pair_unit_chk #(
    .BYTE_W   (BYTE_W),
    .ADDR_CFG (ADDR_CFG)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sfr_addr_i  (sfr_addr_i),
    .sfr_rdata_o (sfr_rdata_o),
    .ptr_wr_lo_i (ptr_wr_lo_i),
    .ptr_wr_hi_i (ptr_wr_hi_i),
    .ptr_wdata_i (ptr_wdata_i),
    .cmd_inc_i   (cmd_inc_i),
    .cmd_xacc_i  (cmd_xacc_i),
    .cmd_alt_i   (cmd_alt_i),
    .sel_ptr_o   (sel_ptr_o),
    .ptr0_o      (ptr0_o),
    .ptr1_o      (ptr1_o),
    .upd_en      (upd_en),
    .dir_dn      (dir_dn),
    .swap        (swap)
);

// File: tb/dptr_pair_unit_tb_top.sv
module dptr_pair_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [1:0]  wr_lo = 2'b00;
    logic [1:0]  wr_hi = 2'b00;
    logic [7:0]  wdata = 8'h00;
    logic        c_inc = 1'b0;
    logic        c_xacc = 1'b0;
    logic        c_alt = 1'b0;
    logic [15:0] sel_ptr;
    logic [15:0] p0;
    logic [15:0] p1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dptr_pair_unit dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sfr_wr_i    (sfr_wr),
        .sfr_addr_i  (sfr_addr),
        .sfr_wdata_i (sfr_wdata),
        .sfr_rdata_o (sfr_rdata),
        .ptr_wr_lo_i (wr_lo),
        .ptr_wr_hi_i (wr_hi),
        .ptr_wdata_i (wdata),
        .cmd_inc_i   (c_inc),
        .cmd_xacc_i  (c_xacc),
        .cmd_alt_i   (c_alt),
        .sel_ptr_o   (sel_ptr),
        .ptr0_o      (p0),
        .ptr1_o      (p1)
    );

    typedef struct packed {
        logic        swr;
        logic [7:0]  saddr;
        logic [7:0]  sdat;
        logic [1:0]  wlo;
        logic [1:0]  whi;
        logic [7:0]  wdat;
        logic        inc;
        logic        xacc;
        logic        alt;
        logic [3:0]  req;
        logic [15:0] e0;
        logic [15:0] e1;
    } vec_t;

    localparam int NVEC = 20;
    // tags: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 8'h00, 2'b01, 2'b00, 8'h34, 1'b0, 1'b0, 1'b0, 4'd8,  16'h0034, 16'h0000},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b01, 8'h12, 1'b0, 1'b0, 1'b0, 4'd8,  16'h1234, 16'h0000},
        '{1'b0, 8'h00, 8'h00, 2'b10, 2'b00, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd8,  16'h1234, 16'h00FF},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b10, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd8,  16'h1234, 16'hFFFF},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3,  16'h1235, 16'hFFFF},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b1, 1'b0, 1'b1, 4'd11, 16'h1235, 16'h0000},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd5,  16'h1235, 16'h0000},
        '{1'b1, 8'hA1, 8'hF0, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6,  16'h1235, 16'h0000},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3,  16'h1234, 16'h0000},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b1, 1'b0, 1'b1, 4'd11, 16'h1234, 16'hFFFF},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd4,  16'h1233, 16'hFFFF},
        '{1'b1, 8'hA2, 8'h01, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7,  16'h1233, 16'hFFFF},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2,  16'h1233, 16'hFFFE},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b1, 1'b1, 4'd4,  16'h1232, 16'hFFFE},
        '{1'b1, 8'hA1, 8'h40, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6,  16'h1232, 16'hFFFE},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd5,  16'h1232, 16'hFFFE},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b1, 1'b1, 4'd4,  16'h1233, 16'hFFFE},
        '{1'b0, 8'h00, 8'h00, 2'b01, 2'b00, 8'hAA, 1'b1, 1'b0, 1'b1, 4'd9,  16'h12AA, 16'hFFFE},
        '{1'b0, 8'h00, 8'h00, 2'b00, 2'b01, 8'h55, 1'b1, 1'b0, 1'b0, 4'd10, 16'h55AA, 16'hFFFF},
        '{1'b1, 8'hA2, 8'h00, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7,  16'h55AA, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sfr_wr = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
        wr_lo = 2'b00; wr_hi = 2'b00; wdata = 8'h00;
        c_inc = 1'b0; c_xacc = 1'b0; c_alt = 1'b0;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        step();
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_check(input logic [7:0] a, input logic [7:0] exp, input string req);
        sfr_addr = a;
        #1;
        chk(req, {8'h00, sfr_rdata}, {8'h00, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ptr0", p0, 16'h0000);
        chk("R1 ptr1", p1, 16'h0000);
        sfr_check(8'hA1, 8'h00, "R1 cfg");
        sfr_check(8'hA2, 8'h00, "R1 aux");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            sfr_wr = VECS[i].swr; sfr_addr = VECS[i].saddr; sfr_wdata = VECS[i].sdat;
            wr_lo = VECS[i].wlo; wr_hi = VECS[i].whi; wdata = VECS[i].wdat;
            c_inc = VECS[i].inc; c_xacc = VECS[i].xacc; c_alt = VECS[i].alt;
            step();
            chk($sformatf("R%0d vec%0d ptr0", VECS[i].req, i), p0, VECS[i].e0);
            chk($sformatf("R%0d vec%0d ptr1", VECS[i].req, i), p1, VECS[i].e1);
        end
        idle();
        @(negedge clk);

        // R2 routing, swap clear then set (p0=55AA, p1=FFFF)
        c_alt = 1'b0; #1; chk("R2 normal swap0", sel_ptr, 16'h55AA);
        c_alt = 1'b1; #1; chk("R2 alt swap0", sel_ptr, 16'hFFFF);
        c_alt = 1'b0;
        sfr_write(8'hA2, 8'h01);
        c_alt = 1'b0; #1; chk("R2 normal swap1", sel_ptr, 16'hFFFF);
        c_alt = 1'b1; #1; chk("R2 alt swap1", sel_ptr, 16'h55AA);
        c_alt = 1'b0;
        sfr_write(8'hA2, 8'h00);

        // R4 old value visible during the access cycle (update-enable 0 is set)
        c_xacc = 1'b1; c_alt = 1'b0; #1;
        chk("R4 pre-value", sel_ptr, 16'h55AA);
        step();
        c_xacc = 1'b0;
        chk("R4 post-value", p0, 16'h55AB);

        // R6 reserved nibble
        sfr_write(8'hA1, 8'hFF);
        sfr_check(8'hA1, 8'hF0, "R6 cfg readback");

        // R7 swap bit only
        sfr_write(8'hA2, 8'hFE);
        sfr_check(8'hA2, 8'h00, "R7 aux upper ignored");
        sfr_write(8'hA2, 8'hFF);
        sfr_check(8'hA2, 8'h01, "R7 aux readback");
        sfr_write(8'hA2, 8'h00);

        // R12 unmapped address
        sfr_write(8'hA3, 8'hFF);
        sfr_check(8'hA3, 8'h00, "R12 unmapped read");
        sfr_check(8'hA1, 8'hF0, "R12 cfg untouched");
        sfr_check(8'hA2, 8'h00, "R12 aux untouched");

        // R1 mid-run reset
        rst_n = 1'b0;
        #1;
        chk("R1 rerst ptr0", p0, 16'h0000);
        chk("R1 rerst ptr1", p1, 16'h0000);
        sfr_check(8'hA1, 8'h00, "R1 rerst cfg");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule